// File: doc/BRIEF.md
# Virtually Indexed Four-Way Read/Write Cache

This block is a unified cache controller placed between a processor request port and an external memory port. It holds 4 KB as 64 sets of four ways. Each line is 16 bytes (four 32-bit words). The array is indexed and tagged directly with the virtual address the processor presents, so no translation sits on the lookup path. Each request carries its own cacheable attribute. A global enable input turns caching on or off, and a flush pulse invalidates every line at once.

Every read is looked up whatever its cacheable attribute says, and a hit is served from the array. A read miss marked cacheable fetches the whole line from memory in a four-beat burst into a way picked by a free-running LFSR. The requested word is then returned. A read miss not marked cacheable does one external word read and leaves the array alone. Writes always go through to memory. They update the cached word only on a hit, and they never allocate.

The processor port and the memory request port are valid/ready handshakes with one transaction outstanding. A request is taken only when `req_ready` is high. A response stays valid with stable data until `rsp_ready` is seen. A memory request holds its address, data and kind until `mem_req_ready` is seen. Memory read data returns on `mem_rsp_valid` with no back-pressure: one beat for a single read, or four beats in word order 0 to 3 for a burst.

Top module: `va_cache`

## Requirements
- R1: After reset the block is idle (`req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0), every line is invalid and caching starts disabled until `cache_en` is raised.
- R2: The address is split as byte offset [3:0], word select [3:2], set index [9:4] and tag [31:10]. Addresses that differ only in [3:0] share a line, and addresses that differ in the tag but not in [9:4] occupy separate entries of the same set.
- R3: A read that hits is returned from the array with no memory request, even when `req_cacheable`=0.
- R4: A cacheable read miss with the cache enabled issues one request with `mem_req_burst`=1 at the line-aligned address (bits [3:0] zero). It writes the four returned beats (word 0 first) into one way of the set and returns the requested word.
- R5: An uncacheable read miss issues one single-word read (`mem_req_burst`=0), returns its data and allocates nothing, so repeating it misses again.
- R6: `cache_en` is sampled when a request is accepted. While it is 0, every read is a single external read, no hit is used and nothing is filled, and lines already present are kept for later.
- R7: Every write issues exactly one memory write (`mem_req_write`=1, `mem_req_burst`=0). A write hit also updates the cached word. A write miss allocates nothing.
- R8: A write updates only the entry whose virtual address matches. Another virtual address mapping the same memory word keeps its old cached value.
- R9: A flush pulse leaves every line invalid from the next cycle on.
- R10: A flush at any time during a line fill, including the cycle of the last beat, leaves the filled line invalid, and the requested word is still returned correctly.
- R11: Only one request is in flight (`req_ready`=0 from acceptance until the response is taken). The response data and the memory request fields stay stable while their ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| cache_en | input | 1 | Global cache enable, sampled at request acceptance |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Cacheable attribute of the request |
| req_addr | input | ADDR_W | Virtual byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | Memory write |
| mem_req_burst | output | 1 | Four-beat line read |
| mem_req_addr | output | ADDR_W | Memory byte address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read beat valid |
| mem_rsp_data | input | DATA_W | Memory read beat data |

## Verification
The two functions that can meet in one cycle are the flush command and the completion of a line fill. If the last fill beat marks a line valid in the same cycle that a flush clears the array, the line must come out invalid. The bench memory model raises `flush` together with a chosen beat of a burst, both the final beat and a middle beat. A correct design still returns the requested word, and a re-read of the same address must start a fresh burst on the memory port instead of hitting.

// File: rtl/va_cache_pkg.sv
package va_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } cstate_t;
endpackage

// File: rtl/va_cache_lfsr.sv
// Free-running Galois LFSR; low bits feed victim way selection.
module va_cache_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= {{(W-1){1'b0}}, 1'b1};
    else        s_q <= (s_q >> 1) ^ (s_q[0] ? TAPS : '0);
  end

  assign rnd = s_q[OUT_W-1:0];
endmodule

// File: rtl/va_cache_store.sv
// Tag, valid and data arrays, one generate slice per way.
module va_cache_store #(
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 22
) (
  input  logic                          clk,
  input  logic                          rst_n,
  // lookup
  input  logic [$clog2(SETS)-1:0]       rd_idx,
  input  logic [TAG_W-1:0]              rd_tag,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
  output logic                          hit,
  output logic [$clog2(WAYS)-1:0]       hit_way,
  output logic [DATA_W-1:0]             hit_data,
  // word write
  input  logic                          wr_en,
  input  logic [$clog2(SETS)-1:0]       wr_idx,
  input  logic [$clog2(WAYS)-1:0]       wr_way,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]             wr_data,
  // line state
  input  logic                          inval_en,
  input  logic [$clog2(SETS)-1:0]       inval_idx,
  input  logic [$clog2(WAYS)-1:0]       inval_way,
  input  logic                          set_en,
  input  logic [$clog2(SETS)-1:0]       set_idx,
  input  logic [$clog2(WAYS)-1:0]       set_way,
  input  logic [TAG_W-1:0]              set_tag,
  input  logic                          flush_all
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int DEPTH = SETS * LINE_WORDS;

  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] way_data [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [DATA_W-1:0] dat_mem [DEPTH];
    logic [SETS-1:0]   vld_q;

    always_ff @(posedge clk) begin
      if (set_en && set_way == WAY_W'(w)) tag_mem[set_idx] <= set_tag;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w)) dat_mem[{wr_idx, wr_word}] <= wr_data;
    end

    // flush has priority over a line becoming valid in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n || flush_all)                    vld_q <= '0;
      else if (set_en && set_way == WAY_W'(w))     vld_q[set_idx] <= 1'b1;
      else if (inval_en && inval_way == WAY_W'(w)) vld_q[inval_idx] <= 1'b0;
    end

    assign way_hit[w]  = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign way_data[w] = dat_mem[{rd_idx, rd_word}];
  end

  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = way_data[w];
      end
    end
  end

  assign hit = |way_hit;
endmodule

// File: rtl/va_cache.sv
// Virtually indexed set-associative cache controller (top).
module va_cache
  import va_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int LFSR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_burst,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WORD_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);

  cstate_t           state_q;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata, rdata_q;
  logic              q_write, q_c, q_en, q_burst, kill_q;
  logic [WAY_W-1:0]  q_way;
  logic [WORD_W-1:0] beat_q;

  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [WORD_W-1:0] q_word;
  assign q_idx  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_word = q_addr[BYTE_W +: WORD_W];

  logic              st_hit;
  logic [WAY_W-1:0]  st_hit_way;
  logic [DATA_W-1:0] st_hit_data;
  logic [WAY_W-1:0]  rnd_way;

  logic lk_use, in_look, miss_fill, fill_beat, last_beat, set_en, wr_en;
  logic [WAY_W-1:0]  wr_way;
  logic [WORD_W-1:0] wr_word;
  logic [DATA_W-1:0] wr_data;

  assign in_look   = (state_q == ST_LOOK);
  assign lk_use    = q_en && st_hit;
  assign miss_fill = in_look && !q_write && !lk_use && q_en && q_c;
  assign fill_beat = (state_q == ST_MWAIT) && q_burst && mem_rsp_valid;
  assign last_beat = (beat_q == WORD_W'(LINE_WORDS - 1));
  assign set_en    = fill_beat && last_beat && !kill_q && !flush;
  assign wr_en     = (in_look && q_write && lk_use) || fill_beat;
  assign wr_way    = in_look ? st_hit_way : q_way;
  assign wr_word   = in_look ? q_word : beat_q;
  assign wr_data   = in_look ? q_wdata : mem_rsp_data;

  va_cache_lfsr #(
    .W     (LFSR_W),
    .TAPS  (LFSR_W'(8'hB8)),
    .OUT_W (WAY_W)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd   (rnd_way)
  );

  va_cache_store #(
    .WAYS       (WAYS),
    .SETS       (SETS),
    .LINE_WORDS (LINE_WORDS),
    .DATA_W     (DATA_W),
    .TAG_W      (TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (q_idx),
    .rd_tag    (q_tag),
    .rd_word   (q_word),
    .hit       (st_hit),
    .hit_way   (st_hit_way),
    .hit_data  (st_hit_data),
    .wr_en     (wr_en),
    .wr_idx    (q_idx),
    .wr_way    (wr_way),
    .wr_word   (wr_word),
    .wr_data   (wr_data),
    .inval_en  (miss_fill),
    .inval_idx (q_idx),
    .inval_way (rnd_way),
    .set_en    (set_en),
    .set_idx   (q_idx),
    .set_way   (q_way),
    .set_tag   (q_tag),
    .flush_all (flush)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      q_addr  <= '0;
      q_wdata <= '0;
      rdata_q <= '0;
      q_write <= 1'b0;
      q_c     <= 1'b0;
      q_en    <= 1'b0;
      q_burst <= 1'b0;
      kill_q  <= 1'b0;
      q_way   <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_write <= req_write;
            q_c     <= req_cacheable;
            q_en    <= cache_en;
            q_burst <= 1'b0;
            rdata_q <= '0;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (q_write) begin
            state_q <= ST_MREQ;
          end else if (lk_use) begin
            rdata_q <= st_hit_data;
            state_q <= ST_RESP;
          end else begin
            q_burst <= q_en && q_c;
            q_way   <= rnd_way;
            kill_q  <= 1'b0;
            state_q <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          if (flush) kill_q <= 1'b1;
          if (mem_req_ready) begin
            beat_q  <= '0;
            state_q <= q_write ? ST_RESP : ST_MWAIT;
          end
        end
        ST_MWAIT: begin
          if (flush) kill_q <= 1'b1;
          if (mem_rsp_valid) begin
            if (!q_burst) begin
              rdata_q <= mem_rsp_data;
              state_q <= ST_RESP;
            end else begin
              if (beat_q == q_word) rdata_q <= mem_rsp_data;
              beat_q <= beat_q + 1'b1;
              if (last_beat) state_q <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_write = q_write;
  assign mem_req_burst = q_burst;
  assign mem_req_addr  = q_burst ? {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : q_addr;
  assign mem_req_wdata = q_wdata;
endmodule

// File: rtl/va_cache_chk.sv
// Protocol and ordering checks, bound to the cache top.
module va_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_burst,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              q_en,
  input logic              q_c,
  input logic              q_write,
  input logic              st_hit
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_req_valid));

  assert_fill_only_cached_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_burst) |-> (q_en && q_c && !q_write));

  assert_no_fill_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !q_en) |-> !mem_req_burst);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !st_hit);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_mreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);
endmodule

bind va_cache va_cache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_burst (mem_req_burst),
  .mem_req_addr  (mem_req_addr),
  .q_en          (q_en),
  .q_c           (q_c),
  .q_write       (q_write),
  .st_hit        (st_hit)
);

// File: tb/tb_va_cache.sv
`timescale 1ns/1ps
module tb_va_cache;
  localparam int K_NONE = 0, K_SINGLE = 1, K_BURST = 2, K_WRITE = 3;
  localparam int NV = 12;
  // {write, cacheable, addr, wdata, expected memory traffic kind}
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 1'b1, 32'h0000_0004, 32'h0, 2'd2},
    {1'b0, 1'b1, 32'h0000_0008, 32'h0, 2'd0},
    {1'b0, 1'b0, 32'h0000_000C, 32'h0, 2'd0},
    {1'b0, 1'b0, 32'h0000_0040, 32'h0, 2'd1},
    {1'b0, 1'b0, 32'h0000_0040, 32'h0, 2'd1},
    {1'b1, 1'b1, 32'h0000_0008, 32'hCAFE_0001, 2'd3},
    {1'b0, 1'b1, 32'h0000_0008, 32'h0, 2'd0},
    {1'b1, 1'b1, 32'h0000_0084, 32'h0BAD_0002, 2'd3},
    {1'b0, 1'b0, 32'h0000_0084, 32'h0, 2'd1},
    {1'b0, 1'b1, 32'h0000_0404, 32'h0, 2'd2},
    {1'b0, 1'b1, 32'h0000_0408, 32'h0, 2'd0},
    {1'b0, 1'b1, 32'h0000_0100, 32'h0, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write, mem_req_burst;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  va_cache dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cacheable(req_cacheable), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_burst(mem_req_burst),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0, n_err = 0;
  int n_single = 0, n_burst = 0, n_write = 0;
  logic [31:0] mem_w [4096];
  logic [31:0] last_burst_addr = '0;
  int flush_arm = -1;
  bit done = 1'b0;
  bit bp_toggle = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: accepts with periodic back-pressure, returns beats one cycle later
  initial begin
    bit pend = 0, p_write = 0, p_burst = 0, mflush = 0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    int beats_left = 0, beat = 0, cyc = 0;
    logic [11:0] base = '0;
    for (int i = 0; i < 4096; i++) mem_w[i] = (i * 32'h9E37_79B1) ^ 32'h1234_5678;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mflush) begin flush = 1'b0; mflush = 0; end
      if (pend) begin
        if (p_write) begin
          mem_w[p_addr[13:2]] = p_wdata;
          n_write++;
        end else begin
          beats_left = p_burst ? 4 : 1;
          beat = 0;
          base = p_burst ? {p_addr[13:4], 2'b00} : p_addr[13:2];
          if (p_burst) begin n_burst++; last_burst_addr = p_addr; end
          else n_single++;
        end
        pend = 0;
      end
      if (beats_left > 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_w[base + 12'(beat)];
        if (beat == flush_arm) begin flush = 1'b1; mflush = 1; flush_arm = -1; end
        beat++;
        beats_left--;
      end
      cyc++;
      mem_req_ready = (cyc % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; p_write = mem_req_write; p_burst = mem_req_burst;
        p_addr = mem_req_addr; p_wdata = mem_req_wdata;
      end
    end
  end

  task automatic op(input bit wr, input bit c, input logic [31:0] addr, input logic [31:0] wd,
                    input int kind, input string req, input bit dchk, input logic [31:0] dexp);
    int s0, b0, w0, obs;
    logic [31:0] rd;
    s0 = n_single; b0 = n_burst; w0 = n_write;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cacheable = c; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) @(negedge clk);
    bp_toggle = !bp_toggle;
    if (bp_toggle) repeat (2) @(negedge clk);
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (n_single == s0 && n_burst == b0 && n_write == w0) obs = K_NONE;
    else if (n_single == s0 + 1 && n_burst == b0 && n_write == w0) obs = K_SINGLE;
    else if (n_single == s0 && n_burst == b0 + 1 && n_write == w0) obs = K_BURST;
    else if (n_single == s0 && n_burst == b0 && n_write == w0 + 1) obs = K_WRITE;
    else obs = 7;
    chk(obs == kind, {req, " memory traffic"}, 32'(obs), 32'(kind));
    if (dchk) chk(rd == dexp, {req, " data"}, rd, dexp);
  endtask

  function automatic string vreq(input int i);
    case (i)
      0: return "R4";  1: return "R2";  2: return "R3";  3: return "R5";
      4: return "R5";  5: return "R7";  6: return "R7";  7: return "R7";
      8: return "R7";  9: return "R2";  10: return "R2"; default: return "R6";
    endcase
  endfunction

  initial begin
    logic [31:0] old;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

    // disabled out of reset: plain external reads, no fill (R1, R6)
    op(0, 1, 32'h100, 0, K_SINGLE, "R1 disabled read", 1, mem_w[32'h100 >> 2]);
    op(0, 1, 32'h100, 0, K_SINGLE, "R6 disabled repeat", 1, mem_w[32'h100 >> 2]);
    cache_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] a;
      a = VEC[i][65:34];
      op(VEC[i][67], VEC[i][66], a, VEC[i][33:2], int'(VEC[i][1:0]), vreq(i),
         !VEC[i][67], mem_w[a[13:2]]);
    end

    // R6: disabled ignores a present line, which survives for later
    cache_en = 1'b0;
    op(0, 1, 32'h104, 0, K_SINGLE, "R6 hit ignored", 1, mem_w[32'h104 >> 2]);
    cache_en = 1'b1;
    op(0, 1, 32'h104, 0, K_NONE, "R6 line kept", 1, mem_w[32'h104 >> 2]);

    // R9: flush invalidates everything
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    op(0, 1, 32'h104, 0, K_BURST, "R9 after flush", 1, mem_w[32'h104 >> 2]);
    chk(last_burst_addr == 32'h100, "R4 aligned burst", last_burst_addr, 32'h100);

    // R10: flush together with the last beat, then with a middle beat
    flush_arm = 3;
    op(0, 1, 32'h20C, 0, K_BURST, "R10 flush last beat", 1, mem_w[32'h20C >> 2]);
    op(0, 1, 32'h20C, 0, K_BURST, "R10 line not kept", 1, mem_w[32'h20C >> 2]);
    flush_arm = 1;
    op(0, 1, 32'h304, 0, K_BURST, "R10 flush mid fill", 1, mem_w[32'h304 >> 2]);
    op(0, 1, 32'h304, 0, K_BURST, "R10 refill", 1, mem_w[32'h304 >> 2]);
    op(0, 1, 32'h304, 0, K_NONE, "R10 normal fill kept", 1, mem_w[32'h304 >> 2]);

    // R8: alias 0x4008 and 0x0008 share a memory word
    old = mem_w[32'h8 >> 2];
    op(0, 1, 32'h4008, 0, K_BURST, "R8 alias fill", 1, old);
    op(1, 1, 32'h0008, 32'h1111_2222, K_WRITE, "R8 write other alias", 0, 0);
    op(0, 1, 32'h4008, 0, K_NONE, "R8 alias stale", 1, old);
    op(0, 0, 32'h0008, 0, K_SINGLE, "R8 memory updated", 1, 32'h1111_2222);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule